// File: doc/BRIEF.md
# Multi-Polynomial Pseudo-Random Sequence Checker

This block sits after the word aligner of a serial receive path and checks each aligned parallel word against one of four pseudo-random binary sequences, chosen at run time. It needs no seed from outside. While it has not yet locked, it rebuilds its sequence history from the bits it receives. Once locked, it predicts every following word from its own history and compares the prediction with the received word.

Three registered outputs report the result. A lock flag shows that the checker is synchronised. A one-cycle error pulse marks each locked word that holds at least one wrong bit. A saturating counter totals those words. The two toggle test patterns, alternating bits and long runs, have no check. Selecting either one parks the checker. A clear input restarts it without a full reset.

Top module: `prbs_chk`

## Requirements
- R1: `poly_sel` codes 0, 1, 2 and 3 select the recurrences s[n]=s[n-7]^s[n-6], s[n]=s[n-8]^s[n-7], s[n]=s[n-10]^s[n-7] and s[n]=s[n-23]^s[n-18]. Bit 0 of `in_data` is the earliest bit in time.
- R2: With `wide_mode`=1 all DATA_W bits of a word are checked. With `wide_mode`=0 only the low DATA_W/2 bits are checked, and the upper bits have no effect on any output.
- R3: While unlocked, each accepted word is compared with a prediction and then replaces the history, so the checker reseeds from received bits. While locked, the history advances with the predicted bits. Within one word, the prediction runs freely from the history held before that word.
- R4: `locked` rises on the edge that accepts the 4th consecutive unlocked word whose prediction matches. An unlocked word with a mismatch restarts that run.
- R5: While locked, a word with any mismatched checked bit raises `err_pulse` for exactly the following cycle and adds one to `err_count`.
- R6: `err_count` is 16 bits wide and stays at 65535 once it reaches that value.
- R7: While locked, the 4th consecutive mismatching word clears `locked`. That same word still raises `err_pulse` and counts. A matching word restarts the run of bad words.
- R8: `poly_sel` codes 4 to 7 (the toggle patterns) park the checker: `locked` low, no `err_pulse`, `err_count` held.
- R9: `clr`=1 zeroes `err_count`, `locked`, the history and both run counters on the next edge. It has priority over a valid word in the same cycle.
- R10: A cycle with `in_vld`=0 changes no output and no history.
- R11: All outputs are registered. After `rst`, `locked`, `err_pulse` and `err_count` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart of counter, lock and history |
| in_vld | input | 1 | Qualifies `in_data` |
| in_data | input | DATA_W | Aligned word, bit 0 earliest |
| poly_sel | input | 3 | Sequence select (0..3 checked, 4..7 parked) |
| wide_mode | input | 1 | 1: full word, 0: low half word |
| locked | output | 1 | Checker synchronised |
| err_pulse | output | 1 | Mismatch seen in the last accepted locked word |
| err_count | output | CNT_W | Saturating count of mismatching locked words |

## Verification
Two functions can fall on the same edge: counting an error and giving up lock, and (separately) a restart by clear and the acceptance of a valid word. The bench feeds four corrupted words in a row to a locked checker. The scoreboard then expects `err_pulse`, an incremented count and a falling `locked` together after the 4th word. The bench also drives `clr` together with a valid stream word and expects zeroed outputs and a fresh acquisition. A long run of three bad words and one good word drives the counter into saturation while lock is held.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int HIST_W = 23;
  localparam int IDX_W  = $clog2(HIST_W);

  typedef enum logic [2:0] {
    SEL_P7    = 3'd0,
    SEL_P8    = 3'd1,
    SEL_P10   = 3'd2,
    SEL_P23   = 3'd3,
    SEL_HIFRQ = 3'd4,
    SEL_LOFRQ = 3'd5,
    SEL_RSV6  = 3'd6,
    SEL_RSV7  = 3'd7
  } seq_sel_e;

  function automatic logic is_checked(input logic [2:0] sel);
    return !sel[2];
  endfunction

  // history index of the longest feedback tap (order - 1)
  function automatic logic [IDX_W-1:0] far_tap(input logic [2:0] sel);
    case (seq_sel_e'(sel))
      SEL_P7:  return IDX_W'(6);
      SEL_P8:  return IDX_W'(7);
      SEL_P10: return IDX_W'(9);
      default: return IDX_W'(22);
    endcase
  endfunction

  // history index of the inner feedback tap
  function automatic logic [IDX_W-1:0] near_tap(input logic [2:0] sel);
    case (seq_sel_e'(sel))
      SEL_P7:  return IDX_W'(5);
      SEL_P8:  return IDX_W'(6);
      SEL_P10: return IDX_W'(6);
      default: return IDX_W'(17);
    endcase
  endfunction

endpackage

// File: rtl/prbs_chk_predict.sv
module prbs_chk_predict #(
  parameter int DW = 20,
  parameter int HW = 23,
  localparam int IW   = $clog2(HW),
  localparam int HALF = DW / 2
) (
  input  logic [HW-1:0] hist,
  input  logic [IW-1:0] far_idx,
  input  logic [IW-1:0] near_idx,
  input  logic          wide,
  input  logic          keep_pred,
  input  logic [DW-1:0] rx,
  output logic [DW-1:0] pred,
  output logic [DW-1:0] mask,
  output logic [HW-1:0] hist_nxt
);

  // free-running expansion of the history over one full word
  function automatic logic [DW-1:0] expand(input logic [HW-1:0] h0,
                                           input logic [IW-1:0] fa,
                                           input logic [IW-1:0] na);
    logic [HW-1:0] h;
    logic [DW-1:0] w;
    logic          b;
    h = h0;
    w = '0;
    for (int i = 0; i < DW; i++) begin
      b    = h[fa] ^ h[na];
      w[i] = b;
      h    = {h[HW-2:0], b};
    end
    return w;
  endfunction

  // push the active bits of a word into the history, earliest first
  function automatic logic [HW-1:0] absorb(input logic [HW-1:0] h0,
                                           input logic [DW-1:0] bits,
                                           input logic          full);
    logic [HW-1:0] h;
    h = h0;
    for (int i = 0; i < DW; i++) begin
      if (full || i < HALF) h = {h[HW-2:0], bits[i]};
    end
    return h;
  endfunction

  always_comb begin
    pred     = expand(hist, far_idx, near_idx);
    mask     = wide ? {DW{1'b1}} : {{(DW-HALF){1'b0}}, {HALF{1'b1}}};
    hist_nxt = absorb(hist, keep_pred ? pred : rx, wide);
  end

endmodule

// File: rtl/prbs_chk_track.sv
module prbs_chk_track #(
  parameter int CW     = 16,
  parameter int ACQ_N  = 4,
  parameter int LOSS_N = 4,
  localparam int AW = $clog2(ACQ_N + 1),
  localparam int LW = $clog2(LOSS_N + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          idle,
  input  logic          step,
  input  logic          mism,
  output logic          locked,
  output logic          err_pulse,
  output logic [CW-1:0] err_count
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic [AW-1:0] good_run;
  logic [LW-1:0] bad_run;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      locked    <= 1'b0;
      err_pulse <= 1'b0;
      err_count <= '0;
      good_run  <= '0;
      bad_run   <= '0;
    end else if (idle) begin
      locked    <= 1'b0;
      err_pulse <= 1'b0;
      good_run  <= '0;
      bad_run   <= '0;
    end else begin
      err_pulse <= 1'b0;
      if (step) begin
        if (!locked) begin
          if (mism) begin
            good_run <= '0;
          end else if (good_run == AW'(ACQ_N - 1)) begin
            locked   <= 1'b1;
            good_run <= '0;
            bad_run  <= '0;
          end else begin
            good_run <= good_run + 1'b1;
          end
        end else if (mism) begin
          err_pulse <= 1'b1;
          if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
          if (bad_run == LW'(LOSS_N - 1)) begin
            locked   <= 1'b0;
            bad_run  <= '0;
            good_run <= '0;
          end else begin
            bad_run <= bad_run + 1'b1;
          end
        end else begin
          bad_run <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_chk_pkg::*;
#(
  parameter int DATA_W     = 20,
  parameter int CNT_W      = 16,
  parameter int ACQ_WORDS  = 4,
  parameter int LOSS_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [2:0]        poly_sel,
  input  logic              wide_mode,
  output logic              locked,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_count
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_nxt;
  logic [DATA_W-1:0] pred;
  logic [DATA_W-1:0] mask;
  logic [IDX_W-1:0]  far_idx;
  logic [IDX_W-1:0]  near_idx;
  logic              idle;
  logic              step;
  logic              mism;

  assign idle     = !is_checked(poly_sel);
  assign step     = in_vld && !idle;
  assign far_idx  = far_tap(poly_sel);
  assign near_idx = near_tap(poly_sel);
  assign mism     = |((in_data ^ pred) & mask);

  prbs_chk_predict #(
    .DW (DATA_W),
    .HW (HIST_W)
  ) u_predict (
    .hist      (hist_q),
    .far_idx   (far_idx),
    .near_idx  (near_idx),
    .wide      (wide_mode),
    .keep_pred (locked),
    .rx        (in_data),
    .pred      (pred),
    .mask      (mask),
    .hist_nxt  (hist_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) hist_q <= '0;
    else if (step)  hist_q <= hist_nxt;
  end

  prbs_chk_track #(
    .CW     (CNT_W),
    .ACQ_N  (ACQ_WORDS),
    .LOSS_N (LOSS_WORDS)
  ) u_track (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .idle      (idle),
    .step      (step),
    .mism      (mism),
    .locked    (locked),
    .err_pulse (err_pulse),
    .err_count (err_count)
  );

endmodule

// File: rtl/prbs_chk_sva.sv
module prbs_chk_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic             in_vld,
  input logic [2:0]       poly_sel,
  input logic             locked,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_count
);

  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  AST_LOCK_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(in_vld) && !$past(poly_sel[2]) && !$past(clr) && !err_pulse); // R4

  AST_ERR_FROM_LOCK: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> $past(locked) && $past(in_vld)); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (err_count != $past(err_count)) && !$past(clr) && !$past(rst)
      |-> err_count == $past(err_count) + 1'b1 && err_pulse); // R5

  AST_COUNT_SAT: assert property (@(posedge clk) disable iff (rst)
    ($past(err_count) == TOP) && !$past(clr) && !$past(rst) |-> err_count == TOP); // R6

  AST_PARKED: assert property (@(posedge clk) disable iff (rst)
    $past(poly_sel[2]) && !$past(rst) |-> !locked && !err_pulse && $stable(err_count)); // R8

  AST_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !locked && !err_pulse && err_count == '0); // R9

  AST_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !$past(in_vld) && !$past(clr) && !$past(rst) |-> !err_pulse && $stable(err_count)); // R10

endmodule

bind prbs_chk prbs_chk_sva #(.CNT_W(CNT_W)) u_prbs_chk_sva (
  .clk       (clk),
  .rst       (rst),
  .clr       (clr),
  .in_vld    (in_vld),
  .poly_sel  (poly_sel),
  .locked    (locked),
  .err_pulse (err_pulse),
  .err_count (err_count)
);

// File: tb/test_prbs_chk.sv
module test_prbs_chk;

  localparam int DW   = 20;
  localparam int HALF = DW / 2;
  localparam int CW   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr = 1'b0;
  logic          in_vld = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [2:0]    poly_sel = 3'd0;
  logic          wide_mode = 1'b1;
  logic          locked;
  logic          err_pulse;
  logic [CW-1:0] err_count;

  always #4 clk = ~clk;   // 125 MHz

  prbs_chk #(.DATA_W(DW), .CNT_W(CW)) i_prbs_chk (
    .clk(clk), .rst(rst), .clr(clr), .in_vld(in_vld), .in_data(in_data),
    .poly_sel(poly_sel), .wide_mode(wide_mode),
    .locked(locked), .err_pulse(err_pulse), .err_count(err_count)
  );

  typedef struct {
    logic          lk;
    logic          er;
    logic [CW-1:0] cn;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;

  // stream source
  logic [22:0] gen = 23'h1;
  int          junk = 0;
  // requirement-level model of the checker
  logic [22:0]   mh = '0;
  logic          mlock = 1'b0, merr = 1'b0;
  int            mgood = 0, mbad = 0;
  logic [CW-1:0] mcnt = '0;

  function automatic int far_of(input logic [2:0] s);
    return (s == 3'd0) ? 6 : (s == 3'd1) ? 7 : (s == 3'd2) ? 9 : 22;
  endfunction
  function automatic int near_of(input logic [2:0] s);
    return (s == 3'd0) ? 5 : (s == 3'd1) ? 6 : (s == 3'd2) ? 6 : 17;
  endfunction

  task automatic next_word(input logic [2:0] s, input logic w, output logic [DW-1:0] wd);
    int n;
    logic b;
    n  = w ? DW : HALF;
    wd = '0;
    for (int i = 0; i < n; i++) begin
      b     = gen[far_of(s)] ^ gen[near_of(s)];
      wd[i] = b;
      gen   = {gen[21:0], b};
    end
    if (!w) begin
      junk = junk + 37;
      wd[DW-1:HALF] = HALF'(junk ^ 'h2B5);   // R2: noise in unchecked half
    end
  endtask

  function automatic void model(input logic v, input logic [DW-1:0] d,
                                input logic [2:0] s, input logic w, input logic c);
    logic [22:0] ph, rh;
    logic        p, bad;
    int          n;
    if (c) begin
      mh = '0; mlock = 0; merr = 0; mgood = 0; mbad = 0; mcnt = '0;
    end else if (s[2]) begin
      mlock = 0; merr = 0; mgood = 0; mbad = 0;
    end else begin
      merr = 0;
      if (v) begin
        n = w ? DW : HALF;
        ph = mh; rh = mh; bad = 0;
        for (int i = 0; i < n; i++) begin
          p = ph[far_of(s)] ^ ph[near_of(s)];
          if (p != d[i]) bad = 1;
          ph = {ph[21:0], p};
          rh = {rh[21:0], d[i]};
        end
        mh = mlock ? ph : rh;
        if (!mlock) begin
          if (bad) mgood = 0;
          else if (mgood == 3) begin mlock = 1; mgood = 0; mbad = 0; end
          else mgood++;
        end else if (bad) begin
          merr = 1;
          if (mcnt != 16'hFFFF) mcnt++;
          if (mbad == 3) begin mlock = 0; mbad = 0; mgood = 0; end
          else mbad++;
        end else begin
          mbad = 0;
        end
      end
    end
  endfunction

  task automatic drive(input logic v, input logic [DW-1:0] d, input logic [2:0] s,
                       input logic w, input logic c, input string tag);
    exp_t e;
    @(negedge clk);
    in_vld = v; in_data = d; poly_sel = s; wide_mode = w; clr = c;
    model(v, d, s, w, c);
    e.lk = mlock; e.er = merr; e.cn = mcnt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic clean(input logic [2:0] s, input logic w, input int n, input string tag);
    logic [DW-1:0] wd;
    for (int k = 0; k < n; k++) begin
      next_word(s, w, wd);
      drive(1'b1, wd, s, w, 1'b0, tag);
    end
  endtask

  task automatic dirty(input logic [2:0] s, input logic w, input int n, input string tag);
    logic [DW-1:0] wd;
    for (int k = 0; k < n; k++) begin
      next_word(s, w, wd);
      wd[k % HALF] = ~wd[k % HALF];
      drive(1'b1, wd, s, w, 1'b0, tag);
    end
  endtask

  // scoreboard monitor
  always begin
    exp_t e;
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (locked !== e.lk || err_pulse !== e.er || err_count !== e.cn) begin
        n_fail++;
        $display("FAIL %s lock/err/cnt got %0b/%0b/%0d exp %0b/%0b/%0d",
                 e.tag, locked, err_pulse, err_count, e.lk, e.er, e.cn);
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired with %0d items pending", q.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [DW-1:0] wd;
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if (locked !== 1'b0 || err_pulse !== 1'b0 || err_count !== '0) begin
      n_fail++;
      $display("FAIL R11 reset lock/err/cnt got %0b/%0b/%0d exp 0/0/0",
               locked, err_pulse, err_count);
    end
    @(negedge clk);
    rst = 1'b0;

    // acquisition and error handling on the 7-bit sequence, full words
    drive(1'b0, '0, 3'd0, 1'b1, 1'b1, "R9");
    clean(3'd0, 1'b1, 10, "R4");
    dirty(3'd0, 1'b1, 1, "R5");
    clean(3'd0, 1'b1, 2, "R5");
    dirty(3'd0, 1'b1, 3, "R7");
    clean(3'd0, 1'b1, 1, "R7");
    dirty(3'd0, 1'b1, 4, "R7");          // 4th: error and lock loss together
    clean(3'd0, 1'b1, 8, "R3");          // reseed and relock
    // invalid words carry garbage, stream paused
    drive(1'b0, 20'hFFFFF, 3'd0, 1'b1, 1'b0, "R10");
    drive(1'b0, 20'h0F0F0, 3'd0, 1'b1, 1'b0, "R10");
    drive(1'b0, 20'h12345, 3'd0, 1'b1, 1'b0, "R10");
    clean(3'd0, 1'b1, 2, "R10");
    // clear together with a valid word
    next_word(3'd0, 1'b1, wd);
    drive(1'b1, wd, 3'd0, 1'b1, 1'b1, "R9");
    clean(3'd0, 1'b1, 8, "R3");
    dirty(3'd0, 1'b1, 1, "R5");
    // toggle patterns park the checker
    drive(1'b1, 20'h55555, 3'd4, 1'b1, 1'b0, "R8");
    drive(1'b1, 20'hAAAAA, 3'd4, 1'b1, 1'b0, "R8");
    drive(1'b1, 20'hFFC00, 3'd5, 1'b1, 1'b0, "R8");
    drive(1'b1, 20'h003FF, 3'd5, 1'b0, 1'b0, "R8");

    // other sequences, both widths
    for (int s = 1; s < 4; s++) begin
      for (int w = 0; w < 2; w++) begin
        drive(1'b0, '0, 3'(s), w[0], 1'b1, "R9");
        clean(3'(s), w[0], 12, w[0] ? "R1" : "R2");
        dirty(3'(s), w[0], 1, "R1");
        clean(3'(s), w[0], 2, w[0] ? "R1" : "R2");
      end
    end

    // saturation: keep lock with 3 bad words per good word
    drive(1'b0, '0, 3'd0, 1'b0, 1'b1, "R9");
    clean(3'd0, 1'b0, 8, "R4");
    for (int k = 0; k < 21900; k++) begin
      dirty(3'd0, 1'b0, 3, "R6");
      clean(3'd0, 1'b0, 1, "R6");
    end
    dirty(3'd0, 1'b0, 2, "R6");
    drive(1'b1, 20'h0, 3'd0, 1'b0, 1'b1, "R9");

    repeat (3) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule